// File: doc/BRIEF.md
# Camera Parallel-to-Serial Link Transmitter

This block takes 10-bit camera words and sends them over a two-wire serial link. Each word holds eight pixel bits plus a vertical sync flag and a horizontal sync flag. The two wires are a line clock and a line data signal. The block runs on a bit clock `clk`, and the line clock toggles on every bit-clock cycle. Data is therefore valid on both edges of the line clock, and one word takes five line-clock periods, which is ten bits.

Words arrive on a valid/ready stream that is synchronous to `clk`. A word transfers on a rising edge of `clk` when `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. A source that sees `in_ready` low must hold `in_valid` and its data steady until the transfer happens. A two-entry buffer sits between the stream and the shifter. Back-pressure appears only while both entries are occupied or the link is powered down.

A sequencer controls wake-up. While the active-low power-down input is low, the lines carry no current and the reference clock output is low. When power-down is released, the sequencer waits out a lock interval and also needs the lock-done input. It then drives a low, high, low pattern on the line clock with the data line held low. After that it starts the free-running line clock. Every word begins on a rising line-clock edge, so the receiver finds the word boundary from the first rising edge after the pattern.

Top module: `cam_link_tx`

## Requirements
- R1: While reset or power-down (`pd_n` low) holds, `line_en`, `ser_clk`, `ser_dat`, `in_ready` and `ref_clk_o` are all 0.
- R2: After `pd_n` goes high, `line_en` stays 0 for at least 2*LOCK_CYC bit cycles and for as long as `pll_lock` is 0. With `pll_lock` already high, `line_en` rises on the (2*LOCK_CYC+1)-th rising edge after `pd_n` is sampled high.
- R3: The wake-up pattern holds `ser_clk` low for 2*INIT_CYC bit cycles, then high for 2*INIT_CYC, then low for 2*INIT_CYC. `ser_dat` stays 0 for the whole pattern.
- R4: In the active phase `ser_clk` inverts on every bit cycle. The first active cycle has `ser_clk` high. Each word's first bit is sent in a cycle with `ser_clk` high.
- R5: Word bits go out least significant first. The order is pixel bit 0 through pixel bit 7, then the vertical sync flag, then the horizontal sync flag.
- R6: At a word boundary with an empty buffer, an all-zero word is sent. No extra nonzero word ever appears on the line.
- R7: The buffer holds two words. `in_ready` is low only while it is full or the link is down. Every accepted word is sent exactly once, in acceptance order.
- R8: When `pd_n` is sampled low, all outputs of R1 are 0 from the next cycle on. The buffer is emptied, and the next power-up repeats R2 and R3 in full.
- R9: A pause in incoming words of any length neither restarts the wake-up pattern nor stops the line clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two per line-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| pll_lock | input | 1 | Lock-done indication from the clock source |
| ref_clk_i | input | 1 | Reference clock from the host side |
| ref_clk_o | output | 1 | Reference clock forwarded while awake, low when down |
| in_valid | input | 1 | Camera word valid |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | 8 | Pixel bits |
| in_vsync | input | 1 | Vertical sync flag |
| in_hsync | input | 1 | Horizontal sync flag |
| line_en | output | 1 | Line drivers carry current when 1 |
| ser_clk | output | 1 | Serial line clock |
| ser_dat | output | 1 | Serial line data |

## Verification
The word-boundary load can empty a buffer slot in the same cycle that the stream fills one. Bursts of words with random gaps of zero to three cycles are much faster than the ten-cycle drain rate, so both happen together over and over while the buffer sits near full. A bench receiver rebuilds words from the line, and each word is compared in order against a queue of accepted words. A second collision comes from dropping power-down two cycles after a burst: the drop lands while words are buffered and the shifter is mid-word. The bench then expects silent lines and expects no stale word after the next wake-up.

// File: rtl/cam_link_pkg.sv
package cam_link_pkg;
  localparam int WORD_W = 10;
  localparam int PIX_W  = 8;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_LOCK,
    ST_WAKE_LO,
    ST_WAKE_HI,
    ST_WAKE_LO2,
    ST_RUN
  } link_st_e;

  typedef logic [WORD_W-1:0] link_word_t;
endpackage

// File: rtl/cam_link_seq.sv
module cam_link_seq
  import cam_link_pkg::*;
#(
  parameter int LOCK_T = 8192,
  parameter int INIT_T = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_n,
  input  logic       pll_lock,
  output logic       awake,
  output logic       line_en,
  output logic       run,
  output logic       wake_hi,
  output logic       load,
  output logic [3:0] bidx
);
  localparam int MAXT = (LOCK_T > INIT_T) ? LOCK_T : INIT_T;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LOCK_END = CW'(LOCK_T - 1);
  localparam logic [CW-1:0] INIT_END = CW'(INIT_T - 1);

  link_st_e      st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_OFF;
      cnt  <= '0;
      bidx <= '0;
    end else if (!pd_n) begin
      st   <= ST_OFF;
      cnt  <= '0;
      bidx <= '0;
    end else begin
      case (st)
        ST_OFF: begin
          st  <= ST_LOCK;
          cnt <= '0;
        end
        ST_LOCK: begin
          if (cnt == LOCK_END) begin
            if (pll_lock) begin
              st  <= ST_WAKE_LO;
              cnt <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAKE_LO, ST_WAKE_HI, ST_WAKE_LO2: begin
          if (cnt == INIT_END) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= (st == ST_WAKE_LO) ? ST_WAKE_HI :
                    (st == ST_WAKE_HI) ? ST_WAKE_LO2 : ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          bidx <= (bidx == 4'd9) ? 4'd0 : bidx + 1'b1;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign awake   = (st != ST_OFF);
  assign line_en = (st == ST_WAKE_LO) || (st == ST_WAKE_HI) ||
                   (st == ST_WAKE_LO2) || (st == ST_RUN);
  assign run     = (st == ST_RUN);
  assign wake_hi = (st == ST_WAKE_HI);
  assign load    = ((st == ST_WAKE_LO2) && (cnt == INIT_END)) ||
                   ((st == ST_RUN) && (bidx == 4'd9));
endmodule

// File: rtl/cam_word_buf.sv
module cam_word_buf
  import cam_link_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  link_word_t                 wdata,
  input  logic                       pop,
  output link_word_t                 head,
  output logic                       nonempty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  link_word_t        mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !flush && (wp == AW'(i))) mem[i] <= wdata;
    end
  end

  assign head     = mem[rp];
  assign nonempty = (count != '0);
  assign full     = (count == CNTW'(DEPTH));
endmodule

// File: rtl/cam_word_shifter.sv
module cam_word_shifter
  import cam_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       load,
  input  link_word_t head,
  input  logic       head_ok,
  output logic       pop,
  output logic       bit_o
);
  link_word_t sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (load) begin
      sh <= head_ok ? head : '0;
    end else if (run) begin
      sh <= sh >> 1;
    end else begin
      sh <= '0;
    end
  end

  assign pop   = load && head_ok;
  assign bit_o = run && sh[0];
endmodule

// File: rtl/cam_link_tx.sv
module cam_link_tx
  import cam_link_pkg::*;
#(
  parameter int LOCK_CYC = 4096,
  parameter int INIT_CYC = 12,
  parameter int BUF_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_n,
  input  logic       pll_lock,
  input  logic       ref_clk_i,
  output logic       ref_clk_o,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_vsync,
  input  logic       in_hsync,
  output logic       line_en,
  output logic       ser_clk,
  output logic       ser_dat
);
  localparam int LOCK_T = 2 * LOCK_CYC;
  localparam int INIT_T = 2 * INIT_CYC;
  localparam int CNTW   = $clog2(BUF_DEPTH + 1);

  logic       awake, run, wake_hi, load, pop, head_ok, full;
  logic [3:0] bidx;
  link_word_t head;
  logic [CNTW-1:0] buf_cnt;

  cam_link_seq #(.LOCK_T(LOCK_T), .INIT_T(INIT_T)) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .pll_lock(pll_lock),
    .awake(awake), .line_en(line_en), .run(run), .wake_hi(wake_hi),
    .load(load), .bidx(bidx)
  );

  assign in_ready = awake && !full;

  cam_word_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(!awake),
    .push(in_valid && in_ready),
    .wdata({in_hsync, in_vsync, in_data}),
    .pop(pop), .head(head), .nonempty(head_ok), .full(full),
    .count(buf_cnt)
  );

  cam_word_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load),
    .head(head), .head_ok(head_ok), .pop(pop), .bit_o(ser_dat)
  );

  assign ser_clk   = run ? ~bidx[0] : wake_hi;
  assign ref_clk_o = ref_clk_i && awake;
endmodule

// File: rtl/cam_link_tx_chk.sv
module cam_link_tx_chk #(
  parameter int CNTW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pd_n,
  input logic            pll_lock,
  input logic            in_ready,
  input logic            line_en,
  input logic            ser_clk,
  input logic            ser_dat,
  input logic            ref_clk_o,
  input logic            run,
  input logic [CNTW-1:0] buf_cnt
);
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!line_en && !ser_clk && !ser_dat && !in_ready && !ref_clk_o));

  p_lock_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_lock && !line_en) |=> !line_en);

  p_wake_dat_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en && !run) |-> !ser_dat);

  p_clk_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (ser_clk != $past(ser_clk)));

  p_first_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ser_clk);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt <= CNTW'(2));
endmodule

bind cam_link_tx cam_link_tx_chk #(.CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .pll_lock(pll_lock),
  .in_ready(in_ready), .line_en(line_en), .ser_clk(ser_clk),
  .ser_dat(ser_dat), .ref_clk_o(ref_clk_o), .run(run), .buf_cnt(buf_cnt)
);

// File: tb/tb_cam_link_tx.sv
module tb_cam_link_tx;
  localparam int LOCK_CYC = 20;
  localparam int INIT_CYC = 12;
  localparam int LOCK_T = 2 * LOCK_CYC;
  localparam int INIT_T = 2 * INIT_CYC;

  logic clk = 0, rst_n = 0, pd_n = 0, pll_lock = 0, ref_clk_i = 0;
  logic in_valid = 0, in_vsync = 0, in_hsync = 0;
  logic [7:0] in_data = 0;
  logic ref_clk_o, in_ready, line_en, ser_clk, ser_dat;

  int checks = 0, fails = 0;
  logic [9:0] expq[$];
  int mstate = 0, run_len = 0, bpos = 0;
  logic [9:0] rword;

  always #2.5 clk = ~clk;
  always #3.7 ref_clk_i = ~ref_clk_i;

  cam_link_tx #(.LOCK_CYC(LOCK_CYC), .INIT_CYC(INIT_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .pll_lock(pll_lock),
    .ref_clk_i(ref_clk_i), .ref_clk_o(ref_clk_o), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_vsync(in_vsync),
    .in_hsync(in_hsync), .line_en(line_en), .ser_clk(ser_clk),
    .ser_dat(ser_dat)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] rnd_word();
    logic [9:0] w;
    w = 10'($urandom());
    if (w == 10'd0) w = 10'h155;
    return w;
  endfunction

  // bench receiver: tracks wake-up pattern and rebuilds words
  always @(negedge clk) begin
    if (!line_en) begin
      mstate = 0;
    end else begin
      case (mstate)
        0: begin
          chk(!ser_clk && !ser_dat, "R3 pattern start", {ser_clk, ser_dat}, 0);
          mstate = 1; run_len = 1;
        end
        1, 3: begin
          if (!ser_clk) begin
            run_len++;
            chk(!ser_dat, "R3 data low", ser_dat, 0);
          end else begin
            chk(run_len == INIT_T, "R3 low length", run_len, INIT_T);
            if (mstate == 1) begin
              mstate = 2; run_len = 1;
            end else begin
              mstate = 4; bpos = 0;
              rword = 10'd0;
              rword[0] = ser_dat;
              bpos = 1;
            end
          end
        end
        2: begin
          if (ser_clk) begin
            run_len++;
            chk(!ser_dat, "R3 data low", ser_dat, 0);
          end else begin
            chk(run_len == INIT_T, "R3 high length", run_len, INIT_T);
            mstate = 3; run_len = 1;
          end
        end
        default: begin
          chk(ser_clk == (bpos % 2 == 0), "R4 clock phase", ser_clk, (bpos % 2 == 0));
          rword[bpos] = ser_dat;
          if (bpos == 9) begin
            if (rword != 10'd0) begin
              if (expq.size() == 0) begin
                chk(0, "R6 spurious word", rword, 0);
              end else begin
                logic [9:0] e;
                e = expq.pop_front();
                chk(rword == e, "R5 word order", rword, e);
              end
            end
            bpos = 0;
            rword = 10'd0;
          end else begin
            bpos++;
          end
        end
      endcase
    end
  end

  task automatic push(input logic [9:0] w);
    bit ok;
    in_valid = 1;
    {in_hsync, in_vsync, in_data} = w;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    expq.push_back(w);
    in_valid = 0;
  endtask

  task automatic wait_run();
    for (int i = 0; i < 2000 && mstate != 4; i++) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && expq.size() != 0; i++) @(negedge clk);
    chk(expq.size() == 0, "R7 all words delivered", expq.size(), 0);
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      push(rnd_word());
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "R1 watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk({line_en, ser_clk, ser_dat, in_ready, ref_clk_o} == 0, "R1 reset outputs",
        {line_en, ser_clk, ser_dat, in_ready, ref_clk_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({line_en, ser_clk, ser_dat, in_ready, ref_clk_o} == 0, "R1 power-down outputs",
        {line_en, ser_clk, ser_dat, in_ready, ref_clk_o}, 0);

    // lock gating
    pd_n = 1;
    repeat (100) @(negedge clk);
    chk(!line_en, "R2 waits for lock", line_en, 0);
    chk(in_ready, "R7 ready while awake", in_ready, 1);
    pll_lock = 1;
    k = 0;
    while (!line_en && k < 100) begin @(negedge clk); k++; end
    chk(k == 1, "R2 leaves lock after lock-done", k, 1);
    wait_run();
    chk(mstate == 4, "R4 reached active", mstate, 4);

    // random bursts with back-pressure, plus directed words
    burst(40);
    push(10'h3FF); push(10'h001); push(10'h100); push(10'h200);
    push(10'h080);
    drain();

    // long pause: link stays up, idle words are zero
    repeat (400) @(negedge clk);
    chk(mstate == 4 && line_en, "R9 no restart on pause", mstate, 4);
    chk(expq.size() == 0, "R6 no words from idle", expq.size(), 0);
    burst(10);
    drain();

    // power-down mid-stream
    push(rnd_word()); push(rnd_word());
    pd_n = 0;
    @(negedge clk);
    chk({line_en, ser_clk, ser_dat, in_ready, ref_clk_o} == 0, "R8 off next cycle",
        {line_en, ser_clk, ser_dat, in_ready, ref_clk_o}, 0);
    expq.delete();
    repeat (10) @(negedge clk);
    chk(!line_en && !in_ready, "R8 stays off", {line_en, in_ready}, 0);
    pd_n = 1;
    k = 0;
    while (!line_en && k < 500) begin @(negedge clk); k++; end
    chk(k == LOCK_T + 1, "R2 lock interval after restart", k, LOCK_T + 1);
    wait_run();
    chk(mstate == 4, "R8 wake-up repeated", mstate, 4);
    burst(20);
    drain();
    repeat (30) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule